// File: doc/BRIEF.md
# Register Group Load/Store Sequencer

This block carries out a register-group transfer between a register file and memory, one word or doubleword per memory access. A single start request supplies a base address, a 5-bit list field, a direction (load into registers or store from registers) and an access size. The block then works out which registers take part. It steps the address, presents one request at a time on a simple request/acknowledge memory port, and either writes the returned data into the register file or drives register contents onto the memory write bus.

The low four bits of the list field are a count. When the count is 1 to 9, that many registers are taken in order from a fixed list: 16, 17, 18, 19, 20, 21, 22, 23, then 30. Bit 4 of the field adds register 31 as the final transfer. The block reports `busy` while a sequence runs and pulses `done` when it ends. A start request is accepted only while the block is idle.

Top module: `lsm_sequencer`

## Requirements
- R1: The i-th transfer of the counted group (i from 0) uses register 16+i for i below 8 and register 30 for i equal to 8. The register number is presented on `rf_raddr` during that transfer's request, and for loads it is used as `rf_waddr`.
- R2: When list bits [3:0] are 0 or greater than 9, no register from the fixed list is transferred.
- R3: When list bit 4 is 1, register 31 is transferred after the counted group, at the address that follows the group's last address (the base address if the group is empty).
- R4: The first request uses the base address. Each later request adds 4 when `is_dword` is 0 and 8 when it is 1.
- R5: A load writes the register one cycle after its acknowledge. Word size writes bits [31:0] of `mem_rdata` sign-extended to 64 bits, and doubleword size writes all 64 bits.
- R6: A store raises `mem_we` with the request and drives `mem_wdata` from `rf_rdata` for the register on `rf_raddr`. Memory takes bits [31:0] for word size and all 64 bits for doubleword size.
- R7: Only one request is outstanding. `mem_req`, `mem_addr` and `rf_raddr` hold steady until a cycle in which `mem_ack` is 1.
- R8: `done` is a one-cycle pulse in the cycle after the final acknowledge. `busy` falls in that same cycle, and `mem_req` is low in it.
- R9: A start with nothing to transfer (R2 applies and bit 4 is 0) raises `done` in the next cycle, issues no request and leaves `busy` low.
- R10: `start` is ignored while `busy` is 1. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| base_addr | input | AW | Address of the first transfer |
| reg_list | input | 5 | Bits [3:0] count, bit 4 adds register 31 |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| is_dword | input | 1 | 1 = 64-bit accesses, 0 = 32-bit accesses |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data, valid with mem_ack |
| mem_ack | input | 1 | Request completes this cycle |
| rf_raddr | output | 5 | Register read address for stores |
| rf_rdata | input | DW | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | DW | Register write data |

## Verification
A slot counter that slips or a wrong table entry shows up on the very request it affects, as a wrong `rf_raddr`, and on stores as wrong `mem_wdata`. A wrong address step shows on `mem_addr` at the second request. A miscounted total shows as an extra or missing request, or as a `done` that arrives a cycle off, which the per-cycle comparison catches at once. Sign-extension faults appear on `rf_wdata` one cycle after the acknowledge. A start that leaks in while the block is busy shows as an address reset on the following request.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int LIST_W    = 5;
  localparam int CNT_W     = 4;
  localparam int REG_W     = 5;
  localparam int GROUP_MAX = 9;
  localparam int SLOT_W    = 4;
  localparam logic [REG_W-1:0] LINK_REG = 5'd31;

  typedef enum logic {ST_IDLE, ST_XFER} seq_state_t;

  // fixed group list: 16..23 then 30
  function automatic logic [REG_W-1:0] group_reg(input logic [SLOT_W-1:0] idx);
    if (idx < SLOT_W'(8)) return REG_W'(16) + REG_W'(idx);
    return REG_W'(30);
  endfunction
endpackage

// File: rtl/lsm_plan.sv
module lsm_plan
  import lsm_pkg::*;
(
  input  logic [LIST_W-1:0] reg_list,
  output logic [SLOT_W-1:0] grp_cnt,
  output logic [SLOT_W-1:0] total
);
  logic [CNT_W-1:0] n;
  assign n = reg_list[CNT_W-1:0];

  always_comb begin
    if (n >= CNT_W'(1) && n <= CNT_W'(GROUP_MAX)) grp_cnt = SLOT_W'(n);
    else grp_cnt = '0;
    total = grp_cnt + SLOT_W'(reg_list[LIST_W-1]);
  end
endmodule

// File: rtl/lsm_slot_map.sv
module lsm_slot_map
  import lsm_pkg::*;
(
  input  logic [SLOT_W-1:0] idx,
  input  logic [SLOT_W-1:0] grp_cnt,
  output logic [REG_W-1:0]  reg_num
);
  always_comb begin
    if (idx < grp_cnt) reg_num = group_reg(idx);
    else reg_num = LINK_REG;
  end
endmodule

// File: rtl/lsm_load_fmt.sv
module lsm_load_fmt #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] rdata,
  input  logic          dword,
  output logic [DW-1:0] wdata
);
  localparam int HW = DW / 2;
  always_comb begin
    if (dword) wdata = rdata;
    else wdata = {{HW{rdata[HW-1]}}, rdata[HW-1:0]};
  end
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic              is_load,
  input  logic              is_dword,
  input  logic [SLOT_W-1:0] plan_cnt,
  input  logic [SLOT_W-1:0] plan_total,
  input  logic [REG_W-1:0]  map_reg,
  output logic [SLOT_W-1:0] map_idx,
  output logic [SLOT_W-1:0] map_cnt,
  input  logic [DW-1:0]     fmt_data,
  output logic              dword_o,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [REG_W-1:0]  rf_raddr,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DW-1:0]     rf_wdata
);
  localparam logic [AW-1:0] STEP_W = AW'(4);
  localparam logic [AW-1:0] STEP_D = AW'(8);

  seq_state_t        state_q;
  logic [SLOT_W-1:0] slot_q, cnt_q, total_q;
  logic              load_q, dword_q, req_q, done_q, rfwe_q;
  logic [AW-1:0]     addr_q;
  logic [REG_W-1:0]  raddr_q, waddr_q;
  logic [DW-1:0]     wdata_q;
  logic              last_slot;

  assign busy      = (state_q == ST_XFER);
  assign map_idx   = busy ? slot_q + SLOT_W'(1) : '0;
  assign map_cnt   = busy ? cnt_q : plan_cnt;
  assign last_slot = (slot_q + SLOT_W'(1)) == total_q;
  assign dword_o   = dword_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
      total_q <= '0;
      load_q  <= 1'b0;
      dword_q <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      rfwe_q  <= 1'b0;
      addr_q  <= '0;
      raddr_q <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      rfwe_q <= 1'b0;
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          if (plan_total == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_XFER;
            req_q   <= 1'b1;
            addr_q  <= base_addr;
            load_q  <= is_load;
            dword_q <= is_dword;
            cnt_q   <= plan_cnt;
            total_q <= plan_total;
            slot_q  <= '0;
            raddr_q <= map_reg;
          end
        end
      end else if (mem_ack) begin
        if (load_q) begin
          rfwe_q  <= 1'b1;
          waddr_q <= raddr_q;
          wdata_q <= fmt_data;
        end
        if (last_slot) begin
          state_q <= ST_IDLE;
          req_q   <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          slot_q  <= slot_q + SLOT_W'(1);
          addr_q  <= addr_q + (dword_q ? STEP_D : STEP_W);
          raddr_q <= map_reg;
        end
      end
    end
  end

  assign mem_req  = req_q;
  assign mem_we   = req_q & ~load_q;
  assign mem_addr = addr_q;
  assign rf_raddr = raddr_q;
  assign done     = done_q;
  assign rf_we    = rfwe_q;
  assign rf_waddr = waddr_q;
  assign rf_wdata = wdata_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(rf_raddr)));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req && mem_ack)) |->
      (mem_addr == $past(mem_addr) + (dword_q ? STEP_D : STEP_W)));

  assert_reg_set_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((rf_raddr >= REG_W'(16) && rf_raddr <= REG_W'(23)) ||
                 rf_raddr == REG_W'(30) || rf_raddr == LINK_REG));

  assert_load_write_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_req && mem_ack && !mem_we));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));

  assert_fall_done_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !mem_ack) |=> $stable(mem_addr));
endmodule

// File: rtl/lsm_sequencer.sv
module lsm_sequencer
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [4:0]    reg_list,
  input  logic          is_load,
  input  logic          is_dword,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic [4:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [4:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  logic [SLOT_W-1:0] plan_cnt, plan_total, map_idx, map_cnt;
  logic [REG_W-1:0]  map_reg;
  logic [DW-1:0]     fmt_data;
  logic              dword_q;

  lsm_plan u_plan (
    .reg_list (reg_list),
    .grp_cnt  (plan_cnt),
    .total    (plan_total)
  );

  lsm_slot_map u_map (
    .idx     (map_idx),
    .grp_cnt (map_cnt),
    .reg_num (map_reg)
  );

  lsm_load_fmt #(.DW(DW)) u_fmt (
    .rdata (mem_rdata),
    .dword (dword_q),
    .wdata (fmt_data)
  );

  lsm_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .base_addr  (base_addr),
    .is_load    (is_load),
    .is_dword   (is_dword),
    .plan_cnt   (plan_cnt),
    .plan_total (plan_total),
    .map_reg    (map_reg),
    .map_idx    (map_idx),
    .map_cnt    (map_cnt),
    .fmt_data   (fmt_data),
    .dword_o    (dword_q),
    .mem_ack    (mem_ack),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .rf_raddr   (rf_raddr),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata)
  );

  // store data comes straight from the register read port
  assign mem_wdata = rf_rdata;
endmodule

// File: tb/lsm_sequencer_test.sv
module lsm_sequencer_test;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 0, rst = 1;
  logic start = 0, is_load = 0, is_dword = 0, mem_ack = 0;
  logic [AW-1:0] base_addr = '0;
  logic [4:0] reg_list = '0;
  logic busy, done, mem_req, mem_we, rf_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [4:0] rf_raddr, rf_waddr;

  always #5 clk = ~clk;

  lsm_sequencer #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .reg_list(reg_list),
    .is_load(is_load), .is_dword(is_dword), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // memory and register file, plus the reference copies
  logic [31:0] mem [256];
  logic [31:0] xmem [256];
  logic [63:0] rf [32];
  logic [63:0] xrf [32];
  logic cur_dw = 0;

  assign rf_rdata = rf[rf_raddr];
  assign mem_rdata = cur_dw ? {mem[mem_addr[9:2] + 8'd1], mem[mem_addr[9:2]]}
                            : {~mem[mem_addr[9:2]], mem[mem_addr[9:2]]};

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack && mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata[31:0];
      if (cur_dw) mem[mem_addr[9:2] + 8'd1] <= mem_wdata[63:32];
    end
  end

  int checks = 0, errors = 0, cycles = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int q_addr[$];
  int q_reg[$];
  bit m_busy = 0, m_done = 0, m_we = 0, m_load = 0, m_dw = 0;
  logic [4:0] m_waddr;
  logic [63:0] m_wdata;
  bit go = 0, g_load = 0, g_dw = 0;
  logic [4:0] g_list;
  logic [31:0] g_base;
  logic [7:0] lfsr = 8'hA7;

  always @(negedge clk) begin
    bit was_busy;
    if (!rst) begin
      cycles++;
      chk(rf_we == m_we, "R5 rf_we", 64'(rf_we), 64'(m_we));
      if (m_we) begin
        chk(rf_waddr == m_waddr, "R1 rf_waddr", 64'(rf_waddr), 64'(m_waddr));
        chk(rf_wdata == m_wdata, "R5 rf_wdata", rf_wdata, m_wdata);
      end
      chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
      chk(busy == m_busy, "R8 busy", 64'(busy), 64'(m_busy));
      chk(mem_req == m_busy, "R7 mem_req", 64'(mem_req), 64'(m_busy));
      if (mem_req && m_busy) begin
        chk(mem_addr == 32'(q_addr[0]), "R4 mem_addr", 64'(mem_addr), 64'(q_addr[0]));
        chk(rf_raddr == 5'(q_reg[0]), "R1 rf_raddr", 64'(rf_raddr), 64'(q_reg[0]));
        chk(mem_we == !m_load, "R6 mem_we", 64'(mem_we), 64'(!m_load));
        if (!m_load) begin
          if (m_dw) chk(mem_wdata == xrf[q_reg[0]], "R6 wdata", mem_wdata, xrf[q_reg[0]]);
          else chk(mem_wdata[31:0] == xrf[q_reg[0]][31:0], "R6 wdata",
                   64'(mem_wdata[31:0]), 64'(xrf[q_reg[0]][31:0]));
        end
      end
      m_we = 0; m_done = 0;
      was_busy = m_busy;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ack = mem_req && m_busy && (lfsr[0] | lfsr[2]);
      if (mem_ack) begin
        int a, r, ix;
        a = q_addr.pop_front(); r = q_reg.pop_front();
        ix = (a >> 2) & 255;
        if (m_load) begin
          m_we = 1; m_waddr = 5'(r);
          m_wdata = m_dw ? {xmem[(ix+1)&255], xmem[ix]} : {{32{xmem[ix][31]}}, xmem[ix]};
          xrf[r] = m_wdata;
        end else begin
          xmem[ix] = xrf[r][31:0];
          if (m_dw) xmem[(ix+1)&255] = xrf[r][63:32];
        end
        if (q_addr.size() == 0) begin m_done = 1; m_busy = 0; end
      end
      start = 0;
      if (go) begin
        go = 0;
        start = 1; base_addr = g_base; reg_list = g_list; is_load = g_load; is_dword = g_dw;
        if (was_busy) begin
          chk(busy == 1'b1, "R10 start while busy", 64'(busy), 64'd1);
        end else begin
          int n, a, st;
          n = int'(g_list[3:0]);
          if (n < 1 || n > 9) n = 0;  // R2
          a = int'(g_base); st = g_dw ? 8 : 4;
          for (int i = 0; i < n; i++) begin
            q_addr.push_back(a); q_reg.push_back(i < 8 ? 16 + i : 30); a += st;
          end
          if (g_list[4]) begin q_addr.push_back(a); q_reg.push_back(31); end  // R3
          m_load = g_load; m_dw = g_dw; cur_dw = g_dw;
          if (q_addr.size() == 0) m_done = 1;  // R9
          else m_busy = 1;
        end
      end
    end
  end

  task automatic launch(input logic [31:0] b, input logic [4:0] l, input bit ld, input bit dw);
    g_base = b; g_list = l; g_load = ld; g_dw = dw; go = 1;
    do @(negedge clk); while (go);
  endtask

  task automatic run(input logic [31:0] b, input logic [4:0] l, input bit ld, input bit dw);
    launch(b, l, ld, dw);
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'(i) * 32'h9E3779B9;
      xmem[i] = mem[i];
    end
    for (int r = 0; r < 32; r++) begin
      rf[r] = {32'hC0DE_0000 | 32'(r), 32'h8765_4300 + 32'(r * 7)};
      xrf[r] = rf[r];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0 && rf_we == 0, "R8 reset state",
        {busy, done, mem_req, rf_we}, 0);
    rst = 0;
    run(32'h40, 5'h03, 1, 0);    // R1 R5 word loads
    run(32'h100, 5'h19, 0, 1);   // R1 R3 R6 dword stores, N=9 plus 31
    run(32'h100, 5'h19, 1, 1);   // R5 dword reload
    run(32'h200, 5'h0A, 1, 0);   // R2 R9 invalid count, no link reg
    run(32'h200, 5'h00, 0, 0);   // R9 zero
    run(32'h300, 5'h10, 0, 0);   // R3 only reg 31, store word
    run(32'h300, 5'h1F, 1, 0);   // R2 R3 invalid count plus reg 31
    run(32'h20, 5'h09, 1, 0);    // R1 table end 30, word sign extension
    // R10: second start while running
    launch(32'h80, 5'h18, 0, 0);
    repeat (2) @(negedge clk);
    launch(32'h3C0, 5'h01, 1, 1);
    do @(negedge clk); while (m_busy);
    repeat (3) @(negedge clk);
    for (int r = 0; r < 32; r++) chk(rf[r] == xrf[r], "R5 final register", rf[r], xrf[r]);
    for (int i = 0; i < 256; i++) chk(mem[i] == xmem[i], "R6 final memory", 64'(mem[i]), 64'(xmem[i]));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule